// File: doc/BRIEF.md
# Scanline-Paced Video Memory Copy Engine

This block moves data from the system address space into the 8 KiB video memory window. Software loads a 16-bit source, a destination inside the video window and a length, then starts a transfer through a byte-wide register port. In the burst mode the whole request is copied at once. In the paced mode one 16-byte chunk is copied each time the display enters horizontal blanking. The engine stalls the processor while it is actually moving bytes.

The length and start register is live while a paced transfer runs. Software can rewrite the addresses or the length between chunks, and it can cancel the transfer. A paced start issued during blanking copies its first chunk at once. The destination wraps inside the video window, and the transfer stops early only when the full 16-bit destination counter overflows. The bus fabric, the memories and the display timing sit outside the block.

Top module: `vdma_engine`

## Requirements
- R1: After reset the control register (select 4) reads 0xFF, `cpu_stall` is low and no video write occurs. Selects 0 to 3 always read 0xFF.
- R2: Register selects are: 0 source high byte, 1 source low byte, 2 destination high byte, 3 destination low byte, 4 control. The low 4 bits of both low bytes are forced to zero. The top 3 bits of the destination high byte do not affect `vram_addr`. A control write with bit 7 clear while no paced transfer runs copies 16×(n+1) bytes, where n is bits 6:0. Each byte goes to `vram_addr` = destination[12:0] + i and carries the source byte at source + i.
- R3: With `dbl_speed` low, each copy cycle writes two bytes (`vram_be` = 2'b11, lane 0 at `vram_addr`, lane 1 at `vram_addr`+1), so a chunk takes 8 cycles. With `dbl_speed` high, each copy cycle writes one byte on lane 0 (`vram_be` = 2'b01), so a chunk takes 16 cycles. `cpu_stall` is high for every copy cycle.
- R4: Control reads return {active_n, remaining} in bits {7, 6:0}. Bit 7 reads 0 from the cycle after a paced start. The remaining length drops by one after each chunk. A paced transfer ends once the chunk at remaining 0 completes, and the register then reads 0xFF.
- R5: A control write with bit 7 set starts a paced transfer. Each `hblank_start` pulse then copies exactly one 16-byte chunk, and `cpu_stall` is high only while that chunk is copying.
- R6: A paced start written while `in_hblank` is high copies its first chunk at once, without waiting for a pulse.
- R7: An `hblank_start` pulse while `vblank` is high copies nothing and leaves the remaining length unchanged. Later pulses outside vertical blank continue the transfer.
- R8: A control write with bit 7 clear during a paced transfer cancels it. No burst starts, the remaining length is kept, bit 7 reads 1 and later pulses copy nothing.
- R9: Between chunks, writes to selects 0 to 3 change the addresses used by the remaining chunks. A control write with bit 7 set replaces the remaining length without stopping the transfer.
- R10: A destination passing video offset 0x1FFF continues at offset 0x0000. A transfer stops early, with bit 7 reading 1, when the 16-bit destination counter (high byte including its top 3 bits) wraps from 0xFFFF to 0x0000.
- R11: A register write that arrives while a chunk is copying does not disturb that chunk. It is held, and `cpu_stall` stays high until the write is applied after the chunk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register select, 0 to 4 |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the selected register |
| hblank_start | input | 1 | One-cycle pulse at the start of horizontal blanking |
| in_hblank | input | 1 | Display currently in horizontal blanking |
| vblank | input | 1 | Display currently in vertical blanking |
| dbl_speed | input | 1 | Double-speed mode, one byte per cycle |
| bank_sel | input | 1 | Current video memory bank |
| src_rd | output | 1 | Source read request |
| src_addr | output | 16 | Source byte address (lane 0) |
| src_data | input | 16 | Source bytes at src_addr (7:0) and src_addr+1 (15:8) |
| vram_we | output | 1 | Video memory write enable |
| vram_bank | output | 1 | Bank for the write |
| vram_addr | output | 13 | Video memory offset for lane 0 |
| vram_data | output | 16 | Write data, lane 0 in 7:0 |
| vram_be | output | 2 | Byte lane enables |
| cpu_stall | output | 1 | Processor hold request |

## Verification
The assertions assume that `dbl_speed` stays constant while a chunk is copying. They also assume that the processor issues no further register write while `cpu_stall` is high, except for the single write already in flight when the stall begins, and that `hblank_start` pulses are at least a chunk apart. The stimulus changes the speed flag only between transfers. It spaces blanking pulses by at least 20 cycles and waits for the stall to drop before every write, except for one deliberate write placed in the first copy cycle of a chunk.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  typedef enum logic [2:0] {
    SEL_SRC_HI = 3'd0,
    SEL_SRC_LO = 3'd1,
    SEL_DST_HI = 3'd2,
    SEL_DST_LO = 3'd3,
    SEL_CTRL   = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [2:0] sel;
    logic [7:0] data;
  } reg_wr_t;
endpackage

// File: rtl/vdma_wrhold.sv
module vdma_wrhold
  import vdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       busy,
  output logic       app_en,
  output reg_wr_t    app_wr,
  output logic       pend_v
);
  logic    pend_v_q, pend_v_n;
  reg_wr_t pend_q, pend_n;
  reg_wr_t live_wr;

  assign live_wr = '{sel: wr_sel, data: wr_data};

  always_comb begin
    pend_v_n = pend_v_q;
    pend_n   = pend_q;
    app_en   = 1'b0;
    app_wr   = live_wr;
    if (busy) begin
      if (wr_en && !pend_v_q) begin
        pend_v_n = 1'b1;
        pend_n   = live_wr;
      end
    end else if (pend_v_q) begin
      app_en   = 1'b1;
      app_wr   = pend_q;
      pend_v_n = 1'b0;
    end else begin
      app_en = wr_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q <= 1'b0;
      pend_q   <= '0;
    end else begin
      pend_v_q <= pend_v_n;
      if (pend_v_n && !pend_v_q) pend_q <= pend_n;
    end
  end

  assign pend_v = pend_v_q;

  // R11: a held write is never overwritten by a second one
  assert_single_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v_q |-> !wr_en);
endmodule

// File: rtl/vdma_mover.sv
module vdma_mover #(
  parameter int CHUNK_LG = 4,
  parameter int SRC_W    = 16,
  parameter int VA_W     = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       cont,
  input  logic                       dbl,
  input  logic [SRC_W-CHUNK_LG-1:0]  src_base,
  input  logic [VA_W-CHUNK_LG-1:0]   dst_base,
  input  logic [15:0]                src_data,
  output logic                       busy,
  output logic                       chunk_end,
  output logic                       src_rd,
  output logic [SRC_W-1:0]           src_addr,
  output logic                       vram_we,
  output logic [VA_W-1:0]            vram_addr,
  output logic [15:0]                vram_data,
  output logic [1:0]                 vram_be
);
  localparam logic [CHUNK_LG-1:0] LAST_NORM = CHUNK_LG'((1 << CHUNK_LG) - 2);
  localparam logic [CHUNK_LG-1:0] LAST_DBL  = CHUNK_LG'((1 << CHUNK_LG) - 1);

  logic                busy_q, busy_n;
  logic [CHUNK_LG-1:0] idx_q, idx_n, step;

  assign step      = dbl ? CHUNK_LG'(1) : CHUNK_LG'(2);
  assign chunk_end = busy_q && (idx_q == (dbl ? LAST_DBL : LAST_NORM));

  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    if (start) begin
      busy_n = 1'b1;
      idx_n  = '0;
    end else if (chunk_end) begin
      busy_n = cont;
      idx_n  = '0;
    end else if (busy_q) begin
      idx_n = idx_q + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_n;
      if (busy_q || start) idx_q <= idx_n;
    end
  end

  assign busy      = busy_q;
  assign src_rd    = busy_q;
  assign src_addr  = {src_base, idx_q};
  assign vram_we   = busy_q;
  assign vram_addr = {dst_base, idx_q};
  assign vram_data = dbl ? {8'h00, src_data[7:0]} : src_data;
  assign vram_be   = dbl ? 2'b01 : 2'b11;

  // R11: addresses hold still inside a chunk
  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !chunk_end) |=> ($stable(src_base) && $stable(dst_base)));
  // R5: a chunk that is not continued releases the stall
  assert_chunk_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_end && !cont && !start) |=> !busy_q);
  // R3: a busy period only ends at a chunk boundary
  assert_end_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(chunk_end));
endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
  import vdma_pkg::*;
#(
  parameter int CHUNK_LG = 4,
  parameter int SRC_W    = 16,
  parameter int VA_W     = 13,
  parameter int LEN_W    = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      app_en,
  input  reg_wr_t                   app_wr,
  input  logic                      hblank_start,
  input  logic                      in_hblank,
  input  logic                      vblank,
  input  logic                      busy,
  input  logic                      chunk_end,
  output logic                      start,
  output logic                      cont,
  output logic [SRC_W-CHUNK_LG-1:0] src_base,
  output logic [VA_W-CHUNK_LG-1:0]  dst_base,
  output logic [7:0]                status
);
  localparam int HW = SRC_W - CHUNK_LG;
  localparam int LO = 8 - CHUNK_LG;

  logic [HW-1:0]    src_q, src_n, dst_q, dst_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic             hact_q, hact_n, gp_q, gp_n;
  logic             done, gp_start, paced_new;

  assign done = (len_q == '0) || (&dst_q);
  assign cont = gp_q && !done;

  always_comb begin
    src_n     = src_q;
    dst_n     = dst_q;
    len_n     = len_q;
    hact_n    = hact_q;
    gp_n      = gp_q;
    gp_start  = 1'b0;
    paced_new = 1'b0;
    if (chunk_end) begin
      src_n = src_q + HW'(1);
      dst_n = dst_q + HW'(1);
      len_n = len_q - LEN_W'(1);
      if (done) begin
        hact_n = 1'b0;
        gp_n   = 1'b0;
      end
    end else if (app_en) begin
      unique case (app_wr.sel)
        SEL_SRC_HI: src_n[HW-1:LO] = app_wr.data;
        SEL_SRC_LO: src_n[LO-1:0]  = app_wr.data[7:CHUNK_LG];
        SEL_DST_HI: dst_n[HW-1:LO] = app_wr.data;
        SEL_DST_LO: dst_n[LO-1:0]  = app_wr.data[7:CHUNK_LG];
        SEL_CTRL: begin
          if (app_wr.data[7]) begin
            paced_new = !hact_q;
            hact_n    = 1'b1;
            len_n     = app_wr.data[LEN_W-1:0];
          end else if (hact_q) begin
            hact_n = 1'b0;
          end else begin
            gp_start = 1'b1;
            gp_n     = 1'b1;
            len_n    = app_wr.data[LEN_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  assign start = !busy && (gp_start ||
                 (hact_n && !vblank && (hblank_start || (paced_new && in_hblank))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '1;
      hact_q <= 1'b0;
      gp_q   <= 1'b0;
    end else begin
      src_q  <= src_n;
      dst_q  <= dst_n;
      len_q  <= len_n;
      hact_q <= hact_n;
      gp_q   <= gp_n;
    end
  end

  assign src_base = src_q;
  assign dst_base = dst_q[VA_W-CHUNK_LG-1:0];
  assign status   = {!hact_q, len_q};

  // R4: remaining length steps down by one per chunk
  assert_len_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_end && len_q != '0) |=> (len_q == $past(len_q) - LEN_W'(1)));
  // R4: the final paced chunk leaves the engine idle
  assert_idle_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_end && hact_q && len_q == '0) |=> status[7]);
  // R7: no paced chunk starts from a vertical-blank cycle
  assert_no_vblank_chunk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !gp_q) |-> !$past(vblank));
  // R8: cancel stops the paced transfer without a burst
  assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (app_en && !chunk_end && app_wr.sel == SEL_CTRL && !app_wr.data[7] && hact_q)
    |=> (!busy && status[7]));
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
#(
  parameter int CHUNK_LG = 4,
  parameter int SRC_W    = 16,
  parameter int VA_W     = 13,
  parameter int LEN_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_sel,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             hblank_start,
  input  logic             in_hblank,
  input  logic             vblank,
  input  logic             dbl_speed,
  input  logic             bank_sel,
  output logic             src_rd,
  output logic [SRC_W-1:0] src_addr,
  input  logic [15:0]      src_data,
  output logic             vram_we,
  output logic             vram_bank,
  output logic [VA_W-1:0]  vram_addr,
  output logic [15:0]      vram_data,
  output logic [1:0]       vram_be,
  output logic             cpu_stall
);
  logic                      busy, chunk_end, start, cont, app_en, pend_v;
  reg_wr_t                   app_wr;
  logic [SRC_W-CHUNK_LG-1:0] src_base;
  logic [VA_W-CHUNK_LG-1:0]  dst_base;
  logic [7:0]                status;

  vdma_wrhold u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(reg_sel),
    .wr_data(reg_wdata), .busy(busy), .app_en(app_en), .app_wr(app_wr),
    .pend_v(pend_v)
  );

  vdma_ctrl #(.CHUNK_LG(CHUNK_LG), .SRC_W(SRC_W), .VA_W(VA_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .app_en(app_en), .app_wr(app_wr),
    .hblank_start(hblank_start), .in_hblank(in_hblank), .vblank(vblank),
    .busy(busy), .chunk_end(chunk_end), .start(start), .cont(cont),
    .src_base(src_base), .dst_base(dst_base), .status(status)
  );

  vdma_mover #(.CHUNK_LG(CHUNK_LG), .SRC_W(SRC_W), .VA_W(VA_W)) u_mover (
    .clk(clk), .rst_n(rst_n), .start(start), .cont(cont), .dbl(dbl_speed),
    .src_base(src_base), .dst_base(dst_base), .src_data(src_data),
    .busy(busy), .chunk_end(chunk_end), .src_rd(src_rd), .src_addr(src_addr),
    .vram_we(vram_we), .vram_addr(vram_addr), .vram_data(vram_data),
    .vram_be(vram_be)
  );

  assign vram_bank = bank_sel;
  assign cpu_stall = busy || pend_v;
  assign reg_rdata = (reg_sel == SEL_CTRL) ? status : 8'hFF;

  // R3: every copy cycle holds the processor
  assert_stall_on_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> cpu_stall);
endmodule

// File: tb/vdma_engine_tb_top.sv
module vdma_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = 3'd4;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        hblank_start = 1'b0, in_hblank = 1'b0, vblank = 1'b0;
  logic        dbl_speed = 1'b0, bank_sel = 1'b1;
  logic        src_rd, vram_we, vram_bank, cpu_stall;
  logic [15:0] src_addr, src_data, vram_data;
  logic [12:0] vram_addr;
  logic [1:0]  vram_be;

  int n_checks = 0;
  int n_errors = 0;
  int stall_cnt = 0;
  string cur_tag = "R1";
  logic [20:0] sb_q[$];

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]};
  endfunction

  assign src_data = {mem_byte(src_addr + 16'd1), mem_byte(src_addr)};

  vdma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hblank_start(hblank_start),
    .in_hblank(in_hblank), .vblank(vblank), .dbl_speed(dbl_speed),
    .bank_sel(bank_sel), .src_rd(src_rd), .src_addr(src_addr),
    .src_data(src_data), .vram_we(vram_we), .vram_bank(vram_bank),
    .vram_addr(vram_addr), .vram_data(vram_data), .vram_be(vram_be),
    .cpu_stall(cpu_stall)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard for every lane written
  always @(negedge clk) begin
    if (rst_n && cpu_stall) stall_cnt++;
    if (rst_n && vram_we) begin
      for (int ln = 0; ln < 2; ln++) begin
        if (vram_be[ln]) begin
          logic [12:0] a;
          logic [7:0]  d;
          a = vram_addr + 13'(ln);
          d = ln ? vram_data[15:8] : vram_data[7:0];
          if (sb_q.size() == 0) begin
            check(1'b0, {cur_tag, " unexpected write"}, {a, d}, 0);
          end else begin
            logic [20:0] e;
            e = sb_q.pop_front();
            check({a, d} == e, {cur_tag, " write addr/data"}, {a, d}, e);
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 3'd4;
  endtask

  task automatic hpulse();
    hblank_start = 1'b1;
    @(negedge clk);
    hblank_start = 1'b0;
  endtask

  task automatic expect_chunk(input logic [15:0] s, input logic [12:0] d);
    for (int i = 0; i < 16; i++)
      sb_q.push_back({d + 13'(i), mem_byte(s + 16'(i))});
  endtask

  task automatic set_addr(input logic [7:0] sh, input logic [7:0] sl,
                          input logic [7:0] dh, input logic [7:0] dl);
    wreg(3'd0, sh); wreg(3'd1, sl); wreg(3'd2, dh); wreg(3'd3, dl);
  endtask

  task automatic chk_status(input logic [7:0] exp, input string tag);
    reg_sel = 3'd4;
    #1;
    check(reg_rdata == exp, {tag, " status"}, reg_rdata, exp);
  endtask

  task automatic chk_drained(input string tag);
    check(sb_q.size() == 0, {tag, " all bytes written"}, sb_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    tick(3);
    // R1 reset state
    chk_status(8'hFF, "R1");
    reg_sel = 3'd1; #1;
    check(reg_rdata == 8'hFF, "R1 address reg read", reg_rdata, 8'hFF);
    check(!cpu_stall && !vram_we, "R1 idle outputs", {cpu_stall, vram_we}, 0);
    @(negedge clk); rst_n = 1'b1; tick(2);
    chk_status(8'hFF, "R1");

    // R2 burst with masked addresses, R3 normal speed
    cur_tag = "R2";
    set_addr(8'h12, 8'h34, 8'hE1, 8'h27);
    expect_chunk(16'h1230, 13'h0120);
    expect_chunk(16'h1240, 13'h0130);
    stall_cnt = 0;
    wreg(3'd4, 8'h01);
    tick(30);
    chk_drained("R2");
    check(stall_cnt == 16, "R3 normal speed cycles", stall_cnt, 16);
    chk_status(8'hFF, "R2");

    // R3 double speed
    cur_tag = "R3";
    dbl_speed = 1'b1;
    set_addr(8'h08, 8'h00, 8'h06, 8'h00);
    expect_chunk(16'h0800, 13'h0600);
    stall_cnt = 0;
    wreg(3'd4, 8'h00);
    tick(30);
    chk_drained("R3");
    check(stall_cnt == 16, "R3 double speed cycles", stall_cnt, 16);
    dbl_speed = 1'b0;

    // R4/R5/R7 paced transfer of three chunks
    cur_tag = "R5";
    set_addr(8'h40, 8'h00, 8'h00, 8'h00);
    wreg(3'd4, 8'h82);
    chk_status(8'h02, "R4 active right after start");
    tick(5);
    check(stall_cnt >= 0 && sb_q.size() == 0, "R5 no copy before blank", sb_q.size(), 0);
    expect_chunk(16'h4000, 13'h0000);
    stall_cnt = 0;
    hpulse(); tick(20);
    chk_drained("R5");
    check(stall_cnt == 8, "R5 stall per chunk", stall_cnt, 8);
    chk_status(8'h01, "R4 decrement");
    cur_tag = "R7";
    vblank = 1'b1;
    stall_cnt = 0;
    hpulse(); tick(20);
    check(stall_cnt == 0, "R7 no copy in vblank", stall_cnt, 0);
    chk_status(8'h01, "R7 length kept");
    vblank = 1'b0;
    cur_tag = "R4";
    expect_chunk(16'h4010, 13'h0010);
    hpulse(); tick(20);
    chk_status(8'h00, "R4 at zero");
    expect_chunk(16'h4020, 13'h0020);
    hpulse(); tick(20);
    chk_drained("R4");
    chk_status(8'hFF, "R4 finished");

    // R6 start inside blanking
    cur_tag = "R6";
    set_addr(8'h50, 8'h00, 8'h01, 8'h00);
    in_hblank = 1'b1;
    expect_chunk(16'h5000, 13'h0100);
    stall_cnt = 0;
    wreg(3'd4, 8'h80);
    tick(20);
    chk_drained("R6");
    check(stall_cnt == 8, "R6 immediate chunk", stall_cnt, 8);
    chk_status(8'hFF, "R6");
    in_hblank = 1'b0;

    // R8 cancel
    cur_tag = "R8";
    set_addr(8'h60, 8'h00, 8'h02, 8'h00);
    wreg(3'd4, 8'h85);
    expect_chunk(16'h6000, 13'h0200);
    hpulse(); tick(20);
    chk_drained("R8");
    stall_cnt = 0;
    wreg(3'd4, 8'h00);
    tick(20);
    check(stall_cnt == 0, "R8 no burst after cancel", stall_cnt, 0);
    chk_status(8'h84, "R8 cancelled");
    hpulse(); tick(20);
    check(stall_cnt == 0, "R8 no chunk after cancel", stall_cnt, 0);

    // R9 live rewrite
    cur_tag = "R9";
    set_addr(8'h70, 8'h00, 8'h03, 8'h00);
    wreg(3'd4, 8'h83);
    expect_chunk(16'h7000, 13'h0300);
    hpulse(); tick(20);
    chk_status(8'h02, "R9 before rewrite");
    set_addr(8'h12, 8'h30, 8'h04, 8'h00);
    wreg(3'd4, 8'h80);
    chk_status(8'h00, "R9 length replaced");
    expect_chunk(16'h1230, 13'h0400);
    hpulse(); tick(20);
    chk_drained("R9");
    chk_status(8'hFF, "R9 done");

    // R10 window wrap
    cur_tag = "R10";
    set_addr(8'h20, 8'h00, 8'h1F, 8'hF0);
    expect_chunk(16'h2000, 13'h1FF0);
    expect_chunk(16'h2010, 13'h0000);
    stall_cnt = 0;
    wreg(3'd4, 8'h01);
    tick(30);
    chk_drained("R10 wrap");
    check(stall_cnt == 16, "R10 wrap continues", stall_cnt, 16);

    // R10 full counter overflow stops early
    set_addr(8'h30, 8'h00, 8'hFF, 8'hF0);
    expect_chunk(16'h3000, 13'h1FF0);
    stall_cnt = 0;
    wreg(3'd4, 8'h03);
    tick(50);
    chk_drained("R10 overflow");
    check(stall_cnt == 8, "R10 overflow stop", stall_cnt, 8);
    reg_sel = 3'd4; #1;
    check(reg_rdata[7] == 1'b1, "R10 idle after overflow", reg_rdata[7], 1);

    // R11 write during a chunk is held
    cur_tag = "R11";
    set_addr(8'hA0, 8'h00, 8'h05, 8'h00);
    wreg(3'd4, 8'h81);
    expect_chunk(16'hA000, 13'h0500);
    hpulse();
    check(cpu_stall == 1'b1, "R11 stall in chunk", cpu_stall, 1);
    wreg(3'd1, 8'h80);
    tick(20);
    chk_drained("R11 first chunk");
    chk_status(8'h00, "R11");
    expect_chunk(16'hA080, 13'h0510);
    hpulse(); tick(20);
    chk_drained("R11 held write applied");
    chk_status(8'hFF, "R11 done");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule